// File: doc/BRIEF.md
# AUX Channel Transaction Sequencer

This block runs a single request/reply exchange on a DisplayPort AUX channel for a host. The host presents a 4-bit command type, a 20-bit address, a byte count from 1 to 16 and a 16-byte write payload, then pulses a start strobe. The sequencer then works through a fixed series of steps. It waits for the channel to become quiet and requests ownership of the channel, then waits for the grant code. Next it confirms that a sink is attached. It then drives a lower-level channel engine with a control word, the address and the payload, and polls that engine until the transfer completes.

A failed attempt is retried after a one-cycle engine reset pulse and a back-off delay, up to a bounded number of attempts. The sequencer then returns the read reply, cut to the requested length, together with a 2-bit completion code, and releases ownership. It measures all waits and delays in microseconds, using a tick from a parameterised clock divider. The line coding itself belongs to the engine and is not part of this block.

Top module: `aux_txn_seq`

## Requirements
- R1: If `ch_busy_i` is still high after TIMEOUT_US microsecond ticks, the operation ends with status 1 (busy). Ownership is never requested and no attempt is issued.
- R2: If `own_ack_i` does not equal GRANT_CODE (2'b01) within TIMEOUT_US ticks of the ownership request, the operation ends with status 1 (busy). No attempt is issued.
- R3: If `sink_present_i` is low once ownership is granted, the operation ends with status 2 (no device). No attempt is issued.
- R4: For a write (cmd bit 0 = 0), `eng_wbuf_o` holds the payload with byte k in bits 8k+7:8k, and every byte at index len or above is zero. For a read (cmd bit 0 = 1), `eng_wbuf_o` is all zero.
- R5: During every attempt, `eng_ctrl_o[15:12]` equals the command type, `eng_ctrl_o[7:0]` equals len-1 and `eng_ctrl_o[11:8]` is zero. `eng_addr_o` equals the host address.
- R6: Each attempt is preceded by a one-cycle `eng_reset_o` pulse. Every attempt after the first waits BACKOFF_US further ticks after that pulse before `eng_start_o`.
- R7: If `eng_pending_i` does not fall within TIMEOUT_US ticks after `eng_start_o`, the operation ends at once with status 3 (remote error). No further attempt is made.
- R8: An attempt succeeds when `eng_pending_i` is low and `eng_err_i` is zero, which gives status 0 (ok). Any other outcome is retried, up to MAX_TRIES (32) attempts in total. After that the status is 3.
- R9: After a successful read, `rdata_o` holds `eng_rbuf_i` with the bytes at index len and above zeroed. For any other outcome, `rdata_o` is zero.
- R10: `done_o` is a one-cycle pulse that carries the final `status_o`. `own_req_o` is low while `done_o` is high and whenever the block is idle. Status codes: 0 ok, 1 busy, 2 no device, 3 remote error.
- R11: After reset, `busy_o`, `done_o`, `own_req_o`, `eng_start_o` and `eng_reset_o` are low and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted while not busy |
| cmd_i | input | 4 | Command type, bit 0 set means read |
| addr_i | input | 20 | Target address |
| len_i | input | 5 | Byte count, 1 to 16 |
| wdata_i | input | 128 | Write payload, byte k at bits 8k+7:8k |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| status_o | output | 2 | Completion code |
| rdata_o | output | 128 | Truncated read reply |
| ch_busy_i | input | 1 | Channel still busy with a previous transfer |
| own_req_o | output | 1 | Ownership request, held until release |
| own_ack_i | input | 2 | Ownership acknowledge code |
| sink_present_i | input | 1 | Sink attached |
| eng_ctrl_o | output | 16 | Control word to the engine |
| eng_addr_o | output | 20 | Address to the engine |
| eng_wbuf_o | output | 128 | Write buffer to the engine |
| eng_reset_o | output | 1 | Engine reset pulse |
| eng_start_o | output | 1 | Engine request pulse |
| eng_pending_i | input | 1 | Engine transfer pending |
| eng_err_i | input | 4 | Engine error bits |
| eng_rbuf_i | input | 128 | Engine reply buffer |

## Verification
A sequencer stuck in a wait state, or one that leaves a phase too early, changes the completion code or the number of engine request pulses in a single operation. Both are visible within one timeout period. A faulty retry counter gives the wrong attempt count or the wrong status on the 32nd failed attempt. A missing back-off shortens the gap between consecutive request pulses, and the next retry exposes it. Buffer masking faults appear in `eng_wbuf_o` at the first request pulse, and in `rdata_o` when `done_o` rises.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_BUSY   = 2'd1,
    ST_NODEV  = 2'd2,
    ST_REMOTE = 2'd3
  } aux_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_IDLE, S_WAIT_GRANT, S_SINK, S_RST_HI, S_RST_LO,
    S_BACKOFF, S_ISSUE, S_POLL, S_UNLOAD, S_FINISH
  } aux_state_e;
endpackage

// File: rtl/aux_us_tick.sv
module aux_us_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == CW'(CLK_PER_US - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == CW'(CLK_PER_US - 1));
endmodule

// File: rtl/aux_us_timer.sv
module aux_us_timer #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  // fires on the tick that completes limit_i ticks
  assign last_o = tick_i && (cnt_q == limit_i - W'(1));
endmodule

// File: rtl/aux_byte_mask.sv
module aux_byte_mask #(
  parameter int NBYTES = 16,
  parameter int LEN_W  = 5
) (
  input  logic [NBYTES*8-1:0] data_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic [NBYTES*8-1:0] data_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign data_o[8*b +: 8] = (len_i > LEN_W'(b)) ? data_i[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/aux_txn_seq.sv
module aux_txn_seq
  import aux_seq_pkg::*;
#(
  parameter int         CLK_PER_US = 100,
  parameter int         TIMEOUT_US = 1000,
  parameter int         BACKOFF_US = 400,
  parameter int         MAX_TRIES  = 32,
  parameter int         NBYTES     = 16,
  parameter int         ADDR_W     = 20,
  parameter logic [1:0] GRANT_CODE = 2'b01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [3:0]          cmd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [$clog2(NBYTES+1)-1:0] len_i,
  input  logic [NBYTES*8-1:0] wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          status_o,
  output logic [NBYTES*8-1:0] rdata_o,
  input  logic                ch_busy_i,
  output logic                own_req_o,
  input  logic [1:0]          own_ack_i,
  input  logic                sink_present_i,
  output logic [15:0]         eng_ctrl_o,
  output logic [ADDR_W-1:0]   eng_addr_o,
  output logic [NBYTES*8-1:0] eng_wbuf_o,
  output logic                eng_reset_o,
  output logic                eng_start_o,
  input  logic                eng_pending_i,
  input  logic [3:0]          eng_err_i,
  input  logic [NBYTES*8-1:0] eng_rbuf_i
);
  localparam int LEN_W = $clog2(NBYTES + 1);
  localparam int BUF_W = NBYTES * 8;
  localparam int TMAX  = (TIMEOUT_US > BACKOFF_US) ? TIMEOUT_US : BACKOFF_US;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  aux_state_e state_q, state_d;
  aux_status_e stat_q, stat_d;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, len_in;
  logic [BUF_W-1:0]  wbuf_q, rdata_q, wmask, rmask;
  logic [TRY_W-1:0]  tries_q;
  logic              own_q, tick, tmr_last, tmr_clr;
  logic [TMR_W-1:0]  tmr_limit;

  // out-of-range counts are clamped to 1..NBYTES
  always_comb begin
    if (len_i == '0) len_in = LEN_W'(1);
    else if (len_i > LEN_W'(NBYTES)) len_in = LEN_W'(NBYTES);
    else len_in = len_i;
  end

  aux_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign tmr_limit = (state_q == S_BACKOFF) ? TMR_W'(BACKOFF_US) : TMR_W'(TIMEOUT_US);
  assign tmr_clr   = (state_d != state_q);

  aux_us_timer #(.W(TMR_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .tick_i(tick),
    .limit_i(tmr_limit), .last_o(tmr_last)
  );

  aux_byte_mask #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_wmask (
    .data_i(wdata_i), .len_i(len_in), .data_o(wmask)
  );
  aux_byte_mask #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_rmask (
    .data_i(eng_rbuf_i), .len_i(len_q), .data_o(rmask)
  );

  always_comb begin
    state_d = state_q;
    stat_d  = stat_q;
    unique case (state_q)
      S_IDLE:       if (start_i) begin state_d = S_WAIT_IDLE; stat_d = ST_OK; end
      S_WAIT_IDLE: begin
        if (tick && !ch_busy_i) state_d = S_WAIT_GRANT;
        else if (tmr_last) begin state_d = S_FINISH; stat_d = ST_BUSY; end
      end
      S_WAIT_GRANT: begin
        if (tick && own_ack_i == GRANT_CODE) state_d = S_SINK;
        else if (tmr_last) begin state_d = S_FINISH; stat_d = ST_BUSY; end
      end
      S_SINK: begin
        if (sink_present_i) state_d = S_RST_HI;
        else begin state_d = S_FINISH; stat_d = ST_NODEV; end
      end
      S_RST_HI:  state_d = S_RST_LO;
      S_RST_LO:  state_d = (tries_q == '0) ? S_ISSUE : S_BACKOFF;
      S_BACKOFF: if (tmr_last) state_d = S_ISSUE;
      S_ISSUE:   state_d = S_POLL;
      S_POLL: begin
        if (tick && !eng_pending_i) begin
          if (eng_err_i == '0) state_d = S_UNLOAD;
          else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
            state_d = S_FINISH; stat_d = ST_REMOTE;
          end else state_d = S_RST_HI;
        end else if (tmr_last) begin
          state_d = S_FINISH; stat_d = ST_REMOTE;
        end
      end
      S_UNLOAD:  state_d = S_FINISH;
      S_FINISH:  state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      stat_q  <= ST_OK;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= LEN_W'(1);
      wbuf_q  <= '0;
      rdata_q <= '0;
      tries_q <= '0;
      own_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
      own_q   <= !(state_d inside {S_IDLE, S_WAIT_IDLE, S_FINISH});
      if (state_q == S_IDLE && start_i) begin
        cmd_q   <= cmd_i;
        addr_q  <= addr_i;
        len_q   <= len_in;
        wbuf_q  <= cmd_i[0] ? '0 : wmask;
        rdata_q <= '0;
        tries_q <= '0;
      end
      if (state_q == S_POLL && state_d == S_RST_HI) tries_q <= tries_q + TRY_W'(1);
      if (state_q == S_UNLOAD && cmd_q[0]) rdata_q <= rmask;
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FINISH);
  assign status_o    = stat_q;
  assign rdata_o     = rdata_q;
  assign own_req_o   = own_q;
  assign eng_reset_o = (state_q == S_RST_HI);
  assign eng_start_o = (state_q == S_ISSUE);
  assign eng_addr_o  = addr_q;
  assign eng_wbuf_o  = wbuf_q;
  assign eng_ctrl_o  = {cmd_q, 4'h0, 8'(len_q - LEN_W'(1))};
endmodule

// File: rtl/aux_txn_seq_chk.sv
module aux_txn_seq_chk #(
  parameter int MAX_TRIES = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        own_req_o,
  input logic        eng_start_o,
  input logic        eng_reset_o,
  input logic [15:0] eng_ctrl_o
);
  localparam int CW = $clog2(MAX_TRIES + 2) + 1;
  logic [CW-1:0] att_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) att_q <= '0;
    else if (start_i && !busy_o) att_q <= '0;
    else if (eng_start_o) att_q <= att_q + CW'(1);
  end

  p_start_owned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> own_req_o);
  p_ctrl_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (eng_ctrl_o[11:8] == 4'h0) && (eng_ctrl_o[7:0] < 8'd16));
  p_reset_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_reset_o |=> !eng_reset_o && !eng_start_o);
  p_try_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= CW'(MAX_TRIES));
  p_done_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !own_req_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !own_req_o && !eng_start_o);
endmodule

bind aux_txn_seq aux_txn_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .own_req_o(own_req_o), .eng_start_o(eng_start_o),
  .eng_reset_o(eng_reset_o), .eng_ctrl_o(eng_ctrl_o)
);

// File: tb/aux_txn_seq_test.sv
`timescale 1ns/100ps
module aux_txn_seq_test;
  localparam int CPU = 4;
  localparam int TO  = 8;
  localparam int BO  = 6;
  localparam int MT  = 32;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic start = 0;
  logic [3:0] cmd = 0;
  logic [19:0] addr = 0;
  logic [4:0] len = 1;
  logic [127:0] wdata = 0;
  logic busy, done, own_req, eng_reset, eng_start;
  logic [1:0] status;
  logic [127:0] rdata, wbuf;
  logic [15:0] ctrl;
  logic [19:0] eaddr;
  logic ch_busy, sink = 1, grant_en = 1;
  logic [1:0] own_ack;
  logic pending = 0;
  logic [3:0] err = 0;
  localparam logic [127:0] RBUF = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [127:0] WPAT = 128'hfedcba98_76543210_a5a55a5a_13579bdf;

  assign own_ack = (own_req && grant_en) ? 2'b01 : 2'b10;

  aux_txn_seq #(.CLK_PER_US(CPU), .TIMEOUT_US(TO), .BACKOFF_US(BO), .MAX_TRIES(MT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .addr_i(addr),
    .len_i(len), .wdata_i(wdata), .busy_o(busy), .done_o(done), .status_o(status),
    .rdata_o(rdata), .ch_busy_i(ch_busy), .own_req_o(own_req), .own_ack_i(own_ack),
    .sink_present_i(sink), .eng_ctrl_o(ctrl), .eng_addr_o(eaddr), .eng_wbuf_o(wbuf),
    .eng_reset_o(eng_reset), .eng_start_o(eng_start), .eng_pending_i(pending),
    .eng_err_i(err), .eng_rbuf_i(RBUF)
  );

  // engine / channel model
  logic model_clr = 0, stall = 0;
  int hold = 0, fails = 0;
  int busy_left = 0, att = 0, rst_cnt = 0, lat = 0, cyc = 0, last_st = 0, min_gap = 0;
  logic [15:0] cap_ctrl; logic [19:0] cap_addr; logic [127:0] cap_wbuf;
  assign ch_busy = (busy_left != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (model_clr) begin
      busy_left <= hold; att <= 0; rst_cnt <= 0; pending <= 0; err <= 0; min_gap <= 1000000;
    end else begin
      if (busy_left != 0) busy_left <= busy_left - 1;
      if (eng_reset) rst_cnt <= rst_cnt + 1;
      if (eng_start) begin
        pending <= 1; lat <= 2; att <= att + 1; last_st <= cyc;
        if (att > 0 && (cyc - last_st) < min_gap) min_gap <= cyc - last_st;
        cap_ctrl <= ctrl; cap_addr <= eaddr; cap_wbuf <= wbuf;
      end else if (pending && !stall) begin
        if (lat == 0) begin
          pending <= 0;
          err <= (att <= fails) ? 4'h2 : 4'h0;
        end else lat <= lat - 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] trunc(input logic [127:0] d, input int n);
    logic [127:0] r = '0;
    for (int b = 0; b < 16; b++) if (b < n) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  typedef struct packed {
    logic [3:0] cmd; logic [4:0] len; logic [15:0] hold; logic grant; logic sink;
    logic [7:0] fails; logic stall; logic [1:0] st; logic [7:0] att;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'h9, 5'd4,  16'd0,   1'b1, 1'b1, 8'd0,  1'b0, 2'd0, 8'd1},   // read ok
    '{4'h8, 5'd16, 16'd0,   1'b1, 1'b1, 8'd0,  1'b0, 2'd0, 8'd1},   // write full
    '{4'h8, 5'd3,  16'd0,   1'b1, 1'b1, 8'd2,  1'b0, 2'd0, 8'd3},   // write, 2 retries
    '{4'h9, 5'd1,  16'd200, 1'b1, 1'b1, 8'd0,  1'b0, 2'd1, 8'd0},   // idle timeout
    '{4'h9, 5'd7,  16'd10,  1'b1, 1'b1, 8'd0,  1'b0, 2'd0, 8'd1},   // short busy
    '{4'h9, 5'd2,  16'd0,   1'b0, 1'b1, 8'd0,  1'b0, 2'd1, 8'd0},   // no grant
    '{4'h0, 5'd5,  16'd0,   1'b1, 1'b0, 8'd0,  1'b0, 2'd2, 8'd0},   // no sink
    '{4'h1, 5'd8,  16'd0,   1'b1, 1'b1, 8'd40, 1'b0, 2'd3, 8'd32},  // exhausted
    '{4'h4, 5'd6,  16'd0,   1'b1, 1'b1, 8'd0,  1'b1, 2'd3, 8'd1},   // pending stuck
    '{4'h9, 5'd16, 16'd0,   1'b1, 1'b1, 8'd31, 1'b0, 2'd0, 8'd32}   // last try wins
  };

  logic timed_out = 0;
  task automatic run(input vec_t v, input logic [19:0] a);
    int w = 0;
    @(negedge clk);
    hold = int'(v.hold); fails = int'(v.fails); stall = v.stall;
    grant_en = v.grant; sink = v.sink; model_clr = 1;
    @(negedge clk);
    model_clr = 0; cmd = v.cmd; len = v.len; addr = a; wdata = WPAT; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    if (!done) begin timed_out = 1; chk("R10 done", 0, 1); end
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0); chk("R11 done", done, 0); chk("R11 own", own_req, 0);
    chk("R11 status", status, 0); chk("R11 start", eng_start, 0); chk("R11 reset", eng_reset, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R11 idle", {busy, own_req, eng_start}, 0);

    for (int i = 0; i < 10; i++) begin
      vec_t v = VECS[i];
      logic [19:0] a = 20'h00100 + 20'(i * 4099);
      run(v, a);
      chk("R1/R2/R3/R7/R8 status", status, v.st);
      chk("R10 own released", own_req, 0);
      @(negedge clk);
      chk("R10 done pulse", done, 0);
      chk("R8 attempts", att, v.att);
      chk("R6 reset pulses", rst_cnt, v.att);
      if (v.att != 0) begin
        chk("R5 ctrl", cap_ctrl, {v.cmd, 4'h0, 8'(v.len - 1)});
        chk("R5 addr", cap_addr, a);
        chk("R4 wbuf", cap_wbuf, v.cmd[0] ? 128'h0 : trunc(WPAT, int'(v.len)));
      end
      if (v.att > 1) chk("R6 backoff gap", min_gap >= (BO - 1) * CPU + 4, 1);
      chk("R9 rdata", rdata, (v.cmd[0] && v.st == 2'd0) ? trunc(RBUF, int'(v.len)) : 128'h0);
      repeat (3) @(negedge clk);
    end

    // R9: a later failing read clears stale reply data
    run('{4'h9, 5'd16, 16'd0, 1'b1, 1'b0, 8'd0, 1'b0, 2'd2, 8'd0}, 20'h3);
    chk("R3 nodev after read", status, 2'd2);
    chk("R9 rdata cleared", rdata, 128'h0);
    @(negedge clk);
    chk("R3 no attempt", att, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule